// File: doc/BRIEF.md
# Platform Reset Control Port

This block is a single byte-wide I/O register that software writes to ask the platform for a reset. It sits on the I/O decode of the chipset at port 0xCF9. It claims only byte-sized reads and writes to that exact port. Every other address and every wider access passes it by.

A write with the trigger bit (bit 2) set raises a one-cycle reset request on a dedicated output and leaves the stored byte alone. A write with the trigger bit clear keeps only the reset-type bit (bit 1) and stores every other bit as zero. The stored type bit is driven out continuously, so the downstream reset sequencer can choose a hard reset (1) or a soft reset (0) when the request arrives. A claimed read returns the stored byte, so only bit 1 can ever read back as one.

Accesses are single-cycle. The inputs `ioWr` and `ioRd` qualify `ioAddr`, `ioSize` and `ioWdata` for one clock. The size code is 0 for byte, 1 for word and 2 for dword. Read data is combinational from the stored value. A write takes effect at the clock edge, and the request pulse is high during the cycle that follows the trigger write.

Top module: `sysrst_reg`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first write, the stored byte is 0x00, `hardReset` is 0 and `resetReq` is 0.
- R2: A byte write (`ioSize`=0) to address 0xCF9 with bit 2 of `ioWdata` set drives `resetReq` high for exactly the next clock cycle. A trigger write in each of two consecutive cycles gives a request in each of the two following cycles.
- R3: A trigger write (bit 2 set) leaves the stored byte and `hardReset` unchanged.
- R4: A byte write to 0xCF9 with bit 2 clear stores bit 1 of `ioWdata` as the type bit. All other stored bits become zero, and `resetReq` stays low.
- R5: A byte read (`ioRd`, `ioSize`=0) at 0xCF9 asserts `ioHit` and returns the stored byte on `ioRdata` in the same cycle. Only bit 1 of `ioRdata` can be one.
- R6: Accesses to any other address are ignored: `ioHit` is 0, `ioRdata` is 0x00, the stored byte is unchanged and `resetReq` stays low. This includes the neighbours 0xCF8, 0xCFA and 0xCFB, and addresses that differ only in the upper bits.
- R7: Word and dword accesses are not claimed, even when their address is 0xCF9 or a dword at 0xCF8 covers 0xCF9. They do not change the stored byte, do not raise `resetReq`, and leave `ioHit` at 0.
- R8: `hardReset` always equals the stored type bit, that is bit 1 of what a claimed read returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low platform reset |
| ioAddr | input | 16 | I/O byte address |
| ioSize | input | 2 | Access size: 0 byte, 1 word, 2 dword |
| ioWr | input | 1 | Write strobe, one cycle |
| ioRd | input | 1 | Read strobe, one cycle |
| ioWdata | input | 8 | Write data |
| ioRdata | output | 8 | Read data, zero unless claimed |
| ioHit | output | 1 | High when this block claims the read |
| resetReq | output | 1 | One-cycle platform reset request |
| hardReset | output | 1 | Stored reset type (1 hard, 0 soft) |

## Verification
The assertions check on every clock the following properties:
- every request pulse follows a claimed trigger write;
- trigger writes and unclaimed writes leave the type bit untouched;
- read data is zero outside a claimed read;
- read data never shows a bit other than bit 1.

Only the bench scenarios can show which value a claimed normal write actually stores. They also cover the reset state and back-to-back trigger writes. Finally, they show that neighbouring ports and wider accesses at 0xCF9 are refused, through a read-back of the stored byte after each such access.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;
  localparam logic [1:0] SZ_BYTE  = 2'd0;
  localparam logic [1:0] SZ_WORD  = 2'd1;
  localparam logic [1:0] SZ_DWORD = 2'd2;

  typedef struct packed {
    logic storeType;   // normal claimed write: capture type bit
    logic fireReq;     // claimed write with trigger bit set
    logic typeVal;     // type bit taken from write data
    logic readHit;     // claimed read
  } rcStrobes_t;
endpackage

// File: rtl/sysrst_ctrl.sv
module sysrst_ctrl
  import sysrst_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9,
  parameter int TRIG_BIT = 2,
  parameter int TYPE_BIT = 1
) (
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [1:0]        ioSize,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [DATA_W-1:0] ioWdata,
  output rcStrobes_t        strobes
);
  localparam logic [DATA_W-1:0] TRIG_MASK = DATA_W'(1) << TRIG_BIT;
  localparam logic [DATA_W-1:0] TYPE_MASK = DATA_W'(1) << TYPE_BIT;

  logic addrMatch;
  logic sizeOk;
  logic trigSet;

  always_comb begin
    addrMatch = (ioAddr == PORT_ADDR);
    sizeOk    = (ioSize == SZ_BYTE);
    trigSet   = |(ioWdata & TRIG_MASK);

    strobes.fireReq   = ioWr & addrMatch & sizeOk & trigSet;
    strobes.storeType = ioWr & addrMatch & sizeOk & ~trigSet;
    strobes.typeVal   = |(ioWdata & TYPE_MASK);
    strobes.readHit   = ioRd & addrMatch & sizeOk;
  end
endmodule

// File: rtl/sysrst_dp.sv
module sysrst_dp
  import sysrst_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TYPE_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rcStrobes_t        strobes,
  output logic [DATA_W-1:0] ioRdata,
  output logic              resetReq,
  output logic              typeBit
);
  logic typeReg;
  logic reqReg;
  logic [DATA_W-1:0] storedByte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      typeReg <= 1'b0;
      reqReg  <= 1'b0;
    end else begin
      reqReg <= strobes.fireReq;
      if (strobes.storeType) typeReg <= strobes.typeVal;
    end
  end

  // Stored byte: every bit but the type bit is tied to zero.
  for (genvar b = 0; b < DATA_W; b++) begin : g_byte
    if (b == TYPE_BIT) begin : g_type
      assign storedByte[b] = typeReg;
    end else begin : g_zero
      assign storedByte[b] = 1'b0;
    end
  end

  assign ioRdata  = strobes.readHit ? storedByte : '0;
  assign resetReq = reqReg;
  assign typeBit  = typeReg;
endmodule

// File: rtl/sysrst_reg.sv
module sysrst_reg
  import sysrst_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9,
  parameter int TRIG_BIT = 2,
  parameter int TYPE_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [1:0]        ioSize,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [DATA_W-1:0] ioWdata,
  output logic [DATA_W-1:0] ioRdata,
  output logic              ioHit,
  output logic              resetReq,
  output logic              hardReset
);
  rcStrobes_t strobes;

  sysrst_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_ADDR(PORT_ADDR),
    .TRIG_BIT(TRIG_BIT), .TYPE_BIT(TYPE_BIT)
  ) u_ctrl (
    .ioAddr(ioAddr), .ioSize(ioSize), .ioWr(ioWr), .ioRd(ioRd),
    .ioWdata(ioWdata), .strobes(strobes)
  );

  sysrst_dp #(.DATA_W(DATA_W), .TYPE_BIT(TYPE_BIT)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .ioRdata(ioRdata), .resetReq(resetReq), .typeBit(hardReset)
  );

  assign ioHit = strobes.readHit;
endmodule

// File: rtl/sysrst_reg_chk.sv
module sysrst_reg_chk
  import sysrst_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9,
  parameter int TRIG_BIT = 2,
  parameter int TYPE_BIT = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] ioAddr,
  input logic [1:0]        ioSize,
  input logic              ioWr,
  input logic              ioRd,
  input logic [DATA_W-1:0] ioWdata,
  input logic [DATA_W-1:0] ioRdata,
  input logic              ioHit,
  input logic              resetReq,
  input logic              hardReset
);
  localparam logic [DATA_W-1:0] TYPE_MASK = DATA_W'(1) << TYPE_BIT;

  logic claimed;
  assign claimed = (ioAddr == PORT_ADDR) && (ioSize == SZ_BYTE);

  // R2: a request pulse always follows a claimed trigger write
  assert_req_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resetReq) |-> $past(ioWr && claimed && ioWdata[TRIG_BIT]));

  // R3: a trigger write keeps the type bit
  assert_trigger_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ioWr && claimed && ioWdata[TRIG_BIT]) |=> $stable(hardReset));

  // R4: a normal claimed write raises no request
  assert_normal_noreq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ioWr && claimed && !ioWdata[TRIG_BIT]) |=> !resetReq);

  // R5: only the type bit can read back as one
  assert_read_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ioRdata & ~TYPE_MASK) == '0);

  // R6/R7: unclaimed accesses drive no data and change nothing
  assert_unclaimed_rd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ioRd && claimed) |-> (ioRdata == '0 && !ioHit));
  assert_unclaimed_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ioWr && !claimed) |=> ($stable(hardReset) && !resetReq));

  // R8: exported type matches the byte a claimed read returns
  assert_type_export_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ioRd && claimed) |-> (ioRdata[TYPE_BIT] == hardReset));
endmodule

bind sysrst_reg sysrst_reg_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_ADDR(PORT_ADDR),
  .TRIG_BIT(TRIG_BIT), .TYPE_BIT(TYPE_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ioAddr(ioAddr), .ioSize(ioSize), .ioWr(ioWr),
  .ioRd(ioRd), .ioWdata(ioWdata), .ioRdata(ioRdata), .ioHit(ioHit),
  .resetReq(resetReq), .hardReset(hardReset)
);

// File: tb/sysrst_reg_bench.sv
`timescale 1ns/1ps
module sysrst_reg_bench;
  localparam int PERIOD = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [1:0]  ioSize = '0;
  logic        ioWr = 1'b0;
  logic        ioRd = 1'b0;
  logic [7:0]  ioWdata = '0;
  logic [7:0]  ioRdata;
  logic        ioHit;
  logic        resetReq;
  logic        hardReset;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // reference model state
  int mType = 0;
  int mReq  = 0;

  always #(PERIOD/2) clk = ~clk;

  sysrst_reg u_sysrst_reg (
    .clk(clk), .rst_n(rst_n), .ioAddr(ioAddr), .ioSize(ioSize), .ioWr(ioWr),
    .ioRd(ioRd), .ioWdata(ioWdata), .ioRdata(ioRdata), .ioHit(ioHit),
    .resetReq(resetReq), .hardReset(hardReset)
  );

  task automatic check(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one access cycle, compared against the model before and after the edge
  task automatic access(bit wr, bit rd, int addr, int sz, int data, string req);
    bit claim;
    @(negedge clk);
    ioWr = wr; ioRd = rd; ioAddr = 16'(addr); ioSize = 2'(sz); ioWdata = 8'(data);
    #1;
    claim = (addr == 'hCF9) && (sz == 0);
    check(req, "ioHit", int'(ioHit), (rd && claim) ? 1 : 0);
    check(req, "ioRdata", int'(ioRdata), (rd && claim) ? (mType * 2) : 0);
    @(posedge clk);
    mReq = 0;
    if (wr && claim) begin
      if ((data & 4) != 0) mReq = 1;
      else mType = (data >> 1) & 1;
    end
    #5;
    check(req, "resetReq", int'(resetReq), mReq);
    check(req, "hardReset", int'(hardReset), mType);
    ioWr = 1'b0; ioRd = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int lfsr = 'h5A;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "resetReq in reset", int'(resetReq), 0);
    check("R1", "hardReset in reset", int'(hardReset), 0);
    rst_n = 1'b1;
    access(0, 1, 'hCF9, 0, 0, "R1");
    // R2 + R3: trigger with all bits set, type stays 0
    access(1, 0, 'hCF9, 0, 'hFF, "R2");
    access(0, 1, 'hCF9, 0, 0, "R3");
    // R4: store type, mask the rest
    access(1, 0, 'hCF9, 0, 'h02, "R4");
    access(0, 1, 'hCF9, 0, 0, "R5");
    access(1, 0, 'hCF9, 0, 'hFB, "R4");
    access(0, 1, 'hCF9, 0, 0, "R5");
    // R3: trigger with type bit clear keeps type 1
    access(1, 0, 'hCF9, 0, 'h04, "R3");
    access(0, 1, 'hCF9, 0, 0, "R3");
    // R2: back-to-back triggers
    access(1, 0, 'hCF9, 0, 'h06, "R2");
    access(1, 0, 'hCF9, 0, 'h04, "R2");
    access(0, 0, 'hCF9, 0, 0, "R2");
    // R4: clear type
    access(1, 0, 'hCF9, 0, 'hF9, "R4");
    access(0, 1, 'hCF9, 0, 0, "R8");
    // R6: neighbours and aliases
    access(1, 0, 'hCF8, 0, 'h06, "R6");
    access(1, 0, 'hCFA, 0, 'h02, "R6");
    access(1, 0, 'hCFB, 0, 'h04, "R6");
    access(1, 0, 'h1CF9, 0, 'h02, "R6");
    access(0, 1, 'hCF8, 0, 0, "R6");
    access(0, 1, 'h8CF9, 0, 0, "R6");
    access(0, 1, 'hCF9, 0, 0, "R6");
    // R7: wider accesses
    access(1, 0, 'hCF9, 1, 'h02, "R7");
    access(1, 0, 'hCF8, 2, 'h06, "R7");
    access(1, 0, 'hCF9, 2, 'h04, "R7");
    access(0, 1, 'hCF9, 1, 0, "R7");
    access(0, 1, 'hCF9, 0, 0, "R7");
    // R8: pseudo-random mix
    for (int i = 0; i < 200; i++) begin
      lfsr = ((lfsr << 1) | (((lfsr >> 7) ^ (lfsr >> 5) ^ (lfsr >> 4) ^ (lfsr >> 3)) & 1)) & 'hFF;
      access(lfsr[0], lfsr[1], (lfsr[2] ? 'hCF9 : 'hCF8 + (lfsr & 3)),
             (lfsr[3] ? 0 : (lfsr >> 4) & 3), (lfsr * 37) & 'hFF, "R8");
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule